// File: doc/BRIEF.md
# Endpoint Buffer Ready Controller

This block keeps the buffer-ready flag of a single USB endpoint and decides when a packet may go out on the wire. It listens to events from the serial interface engine (start-of-frame, IN token, receive finished) and to strobes from the processor side (ready write, delayed-start write, byte-count updates, read-empty, toggle, buffer clear and auto clear). It works for either transfer direction, and in the OUT direction it supports one buffer or a ping-pong pair.

For IN traffic there are two ways to start a send. Writing the ready strobe sends on the next IN token. Writing the delayed-start strobe sends on the first IN token that follows a start-of-frame received after that write. The flag also sets by itself when the processor's byte count reaches the programmed maximum packet size. In double-buffer OUT mode the flag rises only when the engine side holds a complete packet and the processor side has been emptied. The visible flag is forced to 0 while a control request is in progress.

Top module: `ep_rdy_ctrl`

## Requirements
- R1: After reset `rdy`, `tx_en` and `dly_pend` are all 0.
- R2: With `cfg_dir_in`=1 (IN; 0 means OUT), a `cpu_rdy_wr` pulse sets `rdy` on the next cycle. The next `sie_in_tok` pulse gives a one-cycle `tx_en` pulse in the cycle after the token is sampled, and `rdy` returns to 0 in that same cycle. Without a token, no `tx_en` occurs.
- R3: On an IN endpoint, a `cpu_wr_vld` pulse whose `cpu_wr_cnt` equals `cfg_max_size` sets `rdy` on the next cycle. A smaller count leaves `rdy` at 0.
- R4: After a `cpu_dly_wr` pulse, `dly_pend` reads 1. IN tokens are ignored until a `sie_sof` has been sampled, and this includes a token that arrives in the same cycle as the SOF. The first token after that SOF produces `tx_en`, and `dly_pend` returns to 0 in the same cycle.
- R5: An SOF sampled before the `cpu_dly_wr` pulse does not arm the delayed start.
- R6: A `cpu_dly_wr` pulse is ignored while `cfg_max_size` is at its top value (all ones, 1023 by default).
- R7: On a single-buffer OUT endpoint (`cfg_dbl`=0), `sie_rx_done` or `cpu_tgl` sets `rdy` on the next cycle.
- R8: On a double-buffer OUT endpoint (`cfg_dbl`=1), `rdy` rises one cycle after the later of two conditions is latched: a packet received on the engine side, and the processor side emptied. The processor side is empty after reset or clear and after `cpu_rd_all`. `cpu_tgl` sets `rdy` directly.
- R9: `cpu_bclr` or `cpu_aclr` clears `rdy` on the next cycle in either direction. On an OUT endpoint, `cpu_rd_all` also clears `rdy` on the next cycle.
- R10: When a set event and a clear event occur in the same cycle, `rdy` ends up 0.
- R11: While `ctl_req`=1, `rdy` is driven to 0 and the internal flag is kept. When `ctl_req` returns to 0, the flag shows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_dbl | input | 1 | 1 = double buffering for OUT |
| cfg_max_size | input | SIZE_W | Maximum packet size in bytes |
| ctl_req | input | 1 | Control request in progress, masks `rdy` |
| sie_sof | input | 1 | Start-of-frame received, one-cycle pulse |
| sie_in_tok | input | 1 | IN token received, one-cycle pulse |
| sie_rx_done | input | 1 | Engine-side reception finished, pulse |
| cpu_wr_vld | input | 1 | Byte count update strobe |
| cpu_wr_cnt | input | SIZE_W | Bytes written so far into the buffer |
| cpu_rd_all | input | 1 | Processor side fully read, pulse |
| cpu_rdy_wr | input | 1 | Write 1 to the ready bit |
| cpu_dly_wr | input | 1 | Write 1 to the delayed-start bit |
| cpu_tgl | input | 1 | Write 1 to the toggle bit |
| cpu_bclr | input | 1 | Buffer clear strobe |
| cpu_aclr | input | 1 | Auto clear strobe |
| rdy | output | 1 | Buffer ready flag (masked by `ctl_req`) |
| tx_en | output | 1 | One-cycle transmit enable |
| dly_pend | output | 1 | Delayed start armed |

## Verification
Setting and clearing the ready flag can both land in the same cycle. The cases are receive-done with buffer clear, the ready write with auto clear, and toggle with read-empty. The bench drives each pair in one cycle and requires the flag to read 0 on the next cycle. A second collision is the SOF and the IN token arriving together while a delayed start is armed. The bench drives them in the same cycle and expects no transmit until a later token arrives.

// File: rtl/ep_rdy_pkg.sv
package ep_rdy_pkg;
   typedef enum logic {
      EP_DIR_OUT = 1'b0,
      EP_DIR_IN  = 1'b1
   } ep_dir_e;

   typedef struct packed {
      logic set;
      logic clr;
   } rdy_req_t;
endpackage

// File: rtl/ep_rdy_flag.sv
module ep_rdy_flag (
   input  logic                  clk,
   input  logic                  rst_n,
   input  ep_rdy_pkg::rdy_req_t  req,
   output logic                  flag_q
);
   // clear beats set
   always_ff @(posedge clk) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (req.clr)    flag_q <= 1'b0;
      else if (req.set)    flag_q <= 1'b1;
   end
endmodule

// File: rtl/ep_iso_arm.sv
module ep_iso_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_in,
   input  logic arm_wr,
   input  logic sof,
   input  logic in_tok,
   input  logic rdy_q,
   output logic tx_fire,
   output logic tx_en_q,
   output logic dly_q,
   output logic sof_seen_q
);
   // a pending delayed start takes over the token decision
   assign tx_fire = dir_in & in_tok & (dly_q ? sof_seen_q : rdy_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en_q    <= 1'b0;
         dly_q      <= 1'b0;
         sof_seen_q <= 1'b0;
      end else begin
         tx_en_q <= tx_fire;
         if (arm_wr)        dly_q <= 1'b1;
         else if (tx_fire)  dly_q <= 1'b0;
         // only an SOF after the write may arm
         if (arm_wr || tx_fire)  sof_seen_q <= 1'b0;
         else if (sof && dly_q)  sof_seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ep_out_dbl.sv
module ep_out_dbl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic flush,
   input  logic rx_done,
   input  logic rd_all,
   input  logic tgl,
   output logic set_req
);
   logic sie_full_q;
   logic cpu_empty_q;
   logic swap;

   assign swap    = sie_full_q & cpu_empty_q;
   assign set_req = en & (swap | tgl);

   always_ff @(posedge clk) begin
      if (!rst_n || !en || flush) begin
         sie_full_q  <= 1'b0;
         cpu_empty_q <= 1'b1;
      end else begin
         if (rx_done)    sie_full_q <= 1'b1;
         else if (swap)  sie_full_q <= 1'b0;
         if (rd_all)       cpu_empty_q <= 1'b1;
         else if (set_req) cpu_empty_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ep_rdy_ctrl.sv
module ep_rdy_ctrl #(
   parameter int SIZE_W = 10,
   parameter bit DBL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dir_in,
   input  logic              cfg_dbl,
   input  logic [SIZE_W-1:0] cfg_max_size,
   input  logic              ctl_req,
   input  logic              sie_sof,
   input  logic              sie_in_tok,
   input  logic              sie_rx_done,
   input  logic              cpu_wr_vld,
   input  logic [SIZE_W-1:0] cpu_wr_cnt,
   input  logic              cpu_rd_all,
   input  logic              cpu_rdy_wr,
   input  logic              cpu_dly_wr,
   input  logic              cpu_tgl,
   input  logic              cpu_bclr,
   input  logic              cpu_aclr,
   output logic              rdy,
   output logic              tx_en,
   output logic              dly_pend
);
   import ep_rdy_pkg::*;

   localparam logic [SIZE_W-1:0] SIZE_TOP = {SIZE_W{1'b1}};

   initial begin
      assert (SIZE_W >= 2 && SIZE_W <= 16)
         else $error("SIZE_W out of range");
   end

   ep_dir_e  dir;
   logic     dir_in;
   logic     arm_wr;
   logic     tx_fire;
   logic     sof_seen_q;
   logic     rdy_q;
   logic     set_in;
   logic     set_out;
   logic     dbl_set;
   logic     dbl_mode;
   logic     flush;
   rdy_req_t req;

   assign dir    = ep_dir_e'(cfg_dir_in);
   assign dir_in = (dir == EP_DIR_IN);
   assign flush  = cpu_bclr | cpu_aclr;
   assign arm_wr = cpu_dly_wr & (cfg_max_size != SIZE_TOP);

   generate
      if (DBL_EN) begin : g_dbl
         assign dbl_mode = ~dir_in & cfg_dbl;
         ep_out_dbl u_dbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (dbl_mode),
            .flush   (flush),
            .rx_done (sie_rx_done),
            .rd_all  (cpu_rd_all),
            .tgl     (cpu_tgl),
            .set_req (dbl_set)
         );
      end else begin : g_single
         logic unused_dbl;
         assign unused_dbl = cfg_dbl;
         assign dbl_mode   = 1'b0;
         assign dbl_set    = 1'b0;
      end
   endgenerate

   assign set_in  = cpu_rdy_wr | (cpu_wr_vld & (cpu_wr_cnt == cfg_max_size));
   assign set_out = dbl_mode ? dbl_set : (sie_rx_done | cpu_tgl);

   assign req.set = dir_in ? set_in : set_out;
   assign req.clr = flush | (dir_in ? tx_fire : cpu_rd_all);

   ep_iso_arm u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_in     (dir_in),
      .arm_wr     (arm_wr),
      .sof        (sie_sof),
      .in_tok     (sie_in_tok),
      .rdy_q      (rdy_q),
      .tx_fire    (tx_fire),
      .tx_en_q    (tx_en),
      .dly_q      (dly_pend),
      .sof_seen_q (sof_seen_q)
   );

   ep_rdy_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .flag_q (rdy_q)
   );

   assign rdy = rdy_q & ~ctl_req;
endmodule

// File: rtl/ep_rdy_ctrl_chk.sv
module ep_rdy_ctrl_chk #(
   parameter int SIZE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_dir_in,
   input logic              cfg_dbl,
   input logic [SIZE_W-1:0] cfg_max_size,
   input logic              ctl_req,
   input logic              sie_rx_done,
   input logic              cpu_rd_all,
   input logic              cpu_dly_wr,
   input logic              cpu_bclr,
   input logic              cpu_aclr,
   input logic              rdy,
   input logic              tx_en,
   input logic              dly_pend,
   input logic              rdy_q,
   input logic              sof_seen_q
);
   // R2
   tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |=> !tx_en);
   // R2
   tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> !rdy_q);
   // R4
   dly_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !$past(cpu_dly_wr)) |-> !dly_pend);
   // R5
   arm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_dly_wr && cfg_max_size != {SIZE_W{1'b1}}) |=> (dly_pend && !sof_seen_q));
   // R6
   top_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_dly_wr && cfg_max_size == {SIZE_W{1'b1}} && !dly_pend) |=> !dly_pend);
   // R7
   out_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && !cfg_dbl && sie_rx_done && !cpu_bclr && !cpu_aclr && !cpu_rd_all)
      |=> rdy_q);
   // R10
   clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_bclr || cpu_aclr) |=> !rdy_q);
   // R11
   mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_req |-> !rdy);
endmodule

bind ep_rdy_ctrl ep_rdy_ctrl_chk #(.SIZE_W(SIZE_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_dir_in   (cfg_dir_in),
   .cfg_dbl      (cfg_dbl),
   .cfg_max_size (cfg_max_size),
   .ctl_req      (ctl_req),
   .sie_rx_done  (sie_rx_done),
   .cpu_rd_all   (cpu_rd_all),
   .cpu_dly_wr   (cpu_dly_wr),
   .cpu_bclr     (cpu_bclr),
   .cpu_aclr     (cpu_aclr),
   .rdy          (rdy),
   .tx_en        (tx_en),
   .dly_pend     (dly_pend),
   .rdy_q        (rdy_q),
   .sof_seen_q   (sof_seen_q)
);

// File: tb/ep_rdy_ctrl_tb_top.sv
module ep_rdy_ctrl_tb_top;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_dir_in, cfg_dbl, ctl_req;
   logic [W-1:0] cfg_max_size, cpu_wr_cnt;
   logic         sie_sof, sie_in_tok, sie_rx_done, cpu_wr_vld, cpu_rd_all;
   logic         cpu_rdy_wr, cpu_dly_wr, cpu_tgl, cpu_bclr, cpu_aclr;
   logic         rdy, tx_en, dly_pend;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ep_rdy_ctrl #(.SIZE_W(W), .DBL_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_dbl(cfg_dbl),
      .cfg_max_size(cfg_max_size), .ctl_req(ctl_req), .sie_sof(sie_sof),
      .sie_in_tok(sie_in_tok), .sie_rx_done(sie_rx_done), .cpu_wr_vld(cpu_wr_vld),
      .cpu_wr_cnt(cpu_wr_cnt), .cpu_rd_all(cpu_rd_all), .cpu_rdy_wr(cpu_rdy_wr),
      .cpu_dly_wr(cpu_dly_wr), .cpu_tgl(cpu_tgl), .cpu_bclr(cpu_bclr),
      .cpu_aclr(cpu_aclr), .rdy(rdy), .tx_en(tx_en), .dly_pend(dly_pend)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic idle_all();
      sie_sof = 0; sie_in_tok = 0; sie_rx_done = 0; cpu_wr_vld = 0;
      cpu_rd_all = 0; cpu_rdy_wr = 0; cpu_dly_wr = 0; cpu_tgl = 0;
      cpu_bclr = 0; cpu_aclr = 0;
   endtask

   task automatic flush();
      cpu_bclr = 1; tick(); cpu_bclr = 0; tick();
   endtask

   task automatic t_reset();
      chk(rdy, 1'b0, "R1", "rdy after reset");
      chk(tx_en, 1'b0, "R1", "tx_en after reset");
      chk(dly_pend, 1'b0, "R1", "dly_pend after reset");
   endtask

   task automatic t_in_ready();
      cfg_dir_in = 1; cfg_max_size = 10'd64;
      cpu_rdy_wr = 1; tick(); cpu_rdy_wr = 0;
      chk(rdy, 1'b1, "R2", "rdy after ready write");
      tick();
      chk(tx_en, 1'b0, "R2", "no tx without token");
      sie_in_tok = 1; tick(); sie_in_tok = 0;
      chk(tx_en, 1'b1, "R2", "tx_en after token");
      chk(rdy, 1'b0, "R2", "rdy cleared at tx");
      tick();
      chk(tx_en, 1'b0, "R2", "tx_en one cycle");
   endtask

   task automatic t_auto();
      cfg_dir_in = 1; cfg_max_size = 10'd64;
      cpu_wr_vld = 1; cpu_wr_cnt = 10'd63; tick();
      chk(rdy, 1'b0, "R3", "count below max");
      cpu_wr_cnt = 10'd64; tick(); cpu_wr_vld = 0;
      chk(rdy, 1'b1, "R3", "count at max");
      cpu_bclr = 1; tick(); cpu_bclr = 0;
      chk(rdy, 1'b0, "R9", "bclr on IN");
   endtask

   task automatic t_dly();
      cfg_dir_in = 1; cfg_max_size = 10'd64;
      cpu_dly_wr = 1; tick(); cpu_dly_wr = 0;
      chk(dly_pend, 1'b1, "R4", "armed after write");
      sie_in_tok = 1; tick(); sie_in_tok = 0;
      chk(tx_en, 1'b0, "R4", "token before SOF");
      sie_sof = 1; sie_in_tok = 1; tick(); sie_sof = 0; sie_in_tok = 0;
      chk(tx_en, 1'b0, "R4", "token same cycle as SOF");
      sie_in_tok = 1; tick(); sie_in_tok = 0;
      chk(tx_en, 1'b1, "R4", "token after SOF");
      chk(dly_pend, 1'b0, "R4", "self clear");
      tick();
   endtask

   task automatic t_pre_sof();
      cfg_dir_in = 1; cfg_max_size = 10'd64;
      cpu_dly_wr = 1; tick(); cpu_dly_wr = 0;
      sie_sof = 1; tick(); sie_sof = 0;
      cpu_dly_wr = 1; tick(); cpu_dly_wr = 0;
      sie_in_tok = 1; tick(); sie_in_tok = 0;
      chk(tx_en, 1'b0, "R5", "SOF before rewrite ignored");
      sie_sof = 1; tick(); sie_sof = 0;
      sie_in_tok = 1; tick(); sie_in_tok = 0;
      chk(tx_en, 1'b1, "R5", "fresh SOF arms");
      tick();
   endtask

   task automatic t_top();
      cfg_dir_in = 1; cfg_max_size = 10'd1023;
      cpu_dly_wr = 1; tick(); cpu_dly_wr = 0;
      chk(dly_pend, 1'b0, "R6", "write ignored at top size");
      sie_sof = 1; tick(); sie_sof = 0;
      sie_in_tok = 1; tick(); sie_in_tok = 0;
      chk(tx_en, 1'b0, "R6", "no tx at top size");
      cfg_max_size = 10'd64;
   endtask

   task automatic t_out_single();
      cfg_dir_in = 0; cfg_dbl = 0; flush();
      sie_rx_done = 1; tick(); sie_rx_done = 0;
      chk(rdy, 1'b1, "R7", "rx_done sets");
      cpu_rd_all = 1; tick(); cpu_rd_all = 0;
      chk(rdy, 1'b0, "R9", "rd_all clears");
      cpu_tgl = 1; tick(); cpu_tgl = 0;
      chk(rdy, 1'b1, "R7", "toggle sets");
      cpu_aclr = 1; tick(); cpu_aclr = 0;
      chk(rdy, 1'b0, "R9", "aclr clears");
   endtask

   task automatic t_out_dbl();
      cfg_dir_in = 0; cfg_dbl = 1; flush();
      sie_rx_done = 1; tick(); sie_rx_done = 0;
      chk(rdy, 1'b0, "R8", "not yet after rx");
      tick();
      chk(rdy, 1'b1, "R8", "set when both done");
      sie_rx_done = 1; tick(); sie_rx_done = 0;
      tick();
      chk(rdy, 1'b1, "R8", "second packet held");
      cpu_rd_all = 1; tick(); cpu_rd_all = 0;
      chk(rdy, 1'b0, "R8", "cleared by read");
      tick();
      chk(rdy, 1'b1, "R8", "pending packet shows");
      cpu_rd_all = 1; tick(); cpu_rd_all = 0;
      tick();
      chk(rdy, 1'b0, "R8", "nothing pending");
      cpu_tgl = 1; tick(); cpu_tgl = 0;
      chk(rdy, 1'b1, "R8", "toggle sets in double");
      flush();
      cfg_dbl = 0;
   endtask

   task automatic t_conflict();
      cfg_dir_in = 0; cfg_dbl = 0; flush();
      sie_rx_done = 1; cpu_bclr = 1; tick(); sie_rx_done = 0; cpu_bclr = 0;
      chk(rdy, 1'b0, "R10", "rx_done vs bclr");
      cpu_tgl = 1; cpu_rd_all = 1; tick(); cpu_tgl = 0; cpu_rd_all = 0;
      chk(rdy, 1'b0, "R10", "toggle vs rd_all");
      cfg_dir_in = 1;
      cpu_rdy_wr = 1; cpu_aclr = 1; tick(); cpu_rdy_wr = 0; cpu_aclr = 0;
      chk(rdy, 1'b0, "R10", "ready write vs aclr");
   endtask

   task automatic t_mask();
      cfg_dir_in = 0; cfg_dbl = 0; flush();
      sie_rx_done = 1; tick(); sie_rx_done = 0;
      ctl_req = 1; #1;
      chk(rdy, 1'b0, "R11", "masked during request");
      tick();
      ctl_req = 0; #1;
      chk(rdy, 1'b1, "R11", "flag kept under mask");
      flush();
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle_all();
      cfg_dir_in = 0; cfg_dbl = 0; cfg_max_size = 10'd64; cpu_wr_cnt = '0; ctl_req = 0;
      rst_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_in_ready();
      t_auto();
      t_dly();
      t_pre_sof();
      t_top();
      t_out_single();
      t_out_dbl();
      t_conflict();
      t_mask();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule